// File: doc/BRIEF.md
# MDIO Paged Register Access Bridge

This block sits behind the station management port of a switch and lets an external management agent reach 32-bit internal control registers using only 16-bit register transactions. A decoded management front end presents it with a five-bit device address, a five-bit register number, a write strobe with 16-bit data and a read strobe. The bridge answers reads on a 16-bit return path and drives a word-addressed 32-bit request/acknowledge bus toward the internal register file.

A page register holds the upper part of the word index. The agent sets it by a write to device address 0x1F, register 0x10. Device addresses 0x10 to 0x17 then open a window of 128 words. Device address bits [2:0] and register bits [4:1] give the lower seven bits of the word index. Register bit 0 selects the half: 0 is bits 15:0 and 1 is bits 31:16. Writes are staged one half at a time, and the whole word goes to the bus only when both halves are in hand. A low-half read fetches the whole word and keeps its upper half, so a high-half read that follows sees the same snapshot. One word, the line integrity word at byte address 0x10C, is answered inside the bridge with a fixed pattern.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the page is 0, `bus_req`, `busy` and `mdio_rvalid` are low, and a read of device 0x1F register 0x10 returns 0x0000.
- R2: A write to device 0x1F register 0x10 loads the page from `mdio_wdata`. A read of that register returns the page, with `mdio_rvalid` high in the cycle after the strobe is taken.
- R3: For device addresses 0x10 to 0x17 the bus word index is {page, device[2:0], register[4:1]}. For example, page 0, device 0x12, register 0x0C or 0x0D is word 0x26 (byte 0x98).
- R4: A half write is staged. A bus write of {high, low} is issued only when the other half of the same word arrives, in either order.
- R5: A half write to a different word, or to a half that is already staged, discards whatever was staged and starts again with the new half.
- R6: A low-half read (register bit 0 = 0) issues a bus read and returns bits 15:0. `mdio_rvalid` is high in the cycle after the acknowledge.
- R7: A high-half read of the word whose upper half was kept by the last low-half read returns the kept bits without a bus access, and then releases them. Any other high-half read fetches the word and returns bits 31:16.
- R8: Any bus write discards the kept upper half.
- R9: Word index 0x43 (page 0, device 0x14, registers 0x06/0x07) reads 0x7FFF on the low half and 0x1800 on the high half, with no bus access. Writes to it are dropped.
- R10: Device addresses outside 0x10–0x17 and 0x1F, and registers of device 0x1F other than 0x10, read 0xFFFF. Writes to them change nothing.
- R11: While `busy` is high, strobes are ignored. If both strobes come in one cycle, the write is taken and the read is dropped with no `mdio_rvalid`.
- R12: `bus_req` stays high with stable `bus_widx`, `bus_we` and `bus_wdata` until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_wr | input | 1 | Register write strobe |
| mdio_rd | input | 1 | Register read strobe |
| mdio_phy | input | 5 | Device address of the access |
| mdio_reg | input | 5 | Register number of the access |
| mdio_wdata | input | 16 | Write data |
| mdio_rdata | output | 16 | Read data, valid with `mdio_rvalid` |
| mdio_rvalid | output | 1 | One-cycle read-complete pulse |
| busy | output | 1 | Bus access in progress; strobes are ignored |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | Request is a write |
| bus_widx | output | PAGE_W+7 | Word index of the request |
| bus_wdata | output | 32 | Write word |
| bus_ack | input | 1 | One-cycle acknowledge |
| bus_rdata | input | 32 | Read word, valid with `bus_ack` |

## Verification
Two functions meet in one host cycle when a write strobe and a read strobe arrive together. The bench provokes this with a page write plus page read in one cycle and judges it by the page value read back and by the absence of a read pulse. A second overlap is a write commit that lands between a low-half read and its high-half partner. The bench provokes it by rewriting the kept word in between and judges it by the high-half data, which must come from the new bus contents. A stretched acknowledge delay lets a strobe arrive while a fetch is outstanding, and the unchanged page shows that the strobe was dropped.

// File: rtl/mdiob_pkg.sv
package mdiob_pkg;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } bridge_st_e;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_PAGE = 2'd1,
    K_DATA = 2'd2,
    K_ID   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mdiob_decode.sv
module mdiob_decode
  import mdiob_pkg::*;
#(
  parameter int unsigned PAGE_W   = 16,
  parameter int unsigned WIDX_W   = PAGE_W + 7,
  parameter int unsigned ID_WIDX  = 'h43,
  parameter logic [4:0]  PAGE_PHY = 5'h1F,
  parameter logic [4:0]  PAGE_REG = 5'h10
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [4:0]        phy,
  input  logic [4:0]        reg_num,
  output acc_kind_e         kind,
  output logic [WIDX_W-1:0] widx,
  output logic              hi_half
);
  logic in_window;

  always_comb begin
    widx      = {page, phy[2:0], reg_num[4:1]};
    hi_half   = reg_num[0];
    in_window = (phy[4:3] == 2'b10);
    if (in_window) begin
      kind = (widx == WIDX_W'(ID_WIDX)) ? K_ID : K_DATA;
    end else if (phy == PAGE_PHY && reg_num == PAGE_REG) begin
      kind = K_PAGE;
    end else begin
      kind = K_NONE;
    end
  end
endmodule

// File: rtl/mdiob_wstage.sv
module mdiob_wstage #(
  parameter int unsigned WIDX_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WIDX_W-1:0] widx,
  input  logic              hi_half,
  input  logic [15:0]       wdata,
  output logic              done,
  output logic [31:0]       word
);
  logic [WIDX_W-1:0] addr_q, addr_d;
  logic              lo_v_q, lo_v_d, hi_v_q, hi_v_d;
  logic [15:0]       lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    done   = take && (addr_q == widx) && (hi_half ? lo_v_q : hi_v_q);
    word   = hi_half ? {wdata, lo_q} : {hi_q, wdata};
    addr_d = addr_q;
    lo_v_d = lo_v_q;
    hi_v_d = hi_v_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (take) begin
      if (done) begin
        lo_v_d = 1'b0;
        hi_v_d = 1'b0;
      end else begin
        addr_d = widx;
        lo_v_d = !hi_half;
        hi_v_d = hi_half;
        if (hi_half) hi_d = wdata;
        else         lo_d = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lo_v_q <= 1'b0;
      hi_v_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (take) begin
      addr_q <= addr_d;
      lo_v_q <= lo_v_d;
      hi_v_q <= hi_v_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end
endmodule

// File: rtl/mdiob_rkeep.sv
module mdiob_rkeep #(
  parameter int unsigned WIDX_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill,
  input  logic              drop,
  input  logic [WIDX_W-1:0] fill_addr,
  input  logic [15:0]       fill_data,
  input  logic [WIDX_W-1:0] look_addr,
  output logic              hit,
  output logic [15:0]       data
);
  logic              v_q, v_d;
  logic [WIDX_W-1:0] a_q, a_d;
  logic [15:0]       d_q, d_d;
  logic              en;

  always_comb begin
    hit = v_q && (a_q == look_addr);
    data = d_q;
    en  = fill || drop;
    v_d = v_q;
    a_d = a_q;
    d_d = d_q;
    if (fill) begin
      v_d = 1'b1;
      a_d = fill_addr;
      d_d = fill_data;
    end else if (drop) begin
      v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      a_q <= '0;
      d_q <= '0;
    end else if (en) begin
      v_q <= v_d;
      a_q <= a_d;
      d_q <= d_d;
    end
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdiob_pkg::*;
#(
  parameter int unsigned PAGE_W    = 16,
  parameter int unsigned ID_WIDX   = 'h43,
  parameter logic [31:0] ID_VALUE  = 32'h1800_7FFF,
  localparam int unsigned WIDX_W   = PAGE_W + 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_wr,
  input  logic              mdio_rd,
  input  logic [4:0]        mdio_phy,
  input  logic [4:0]        mdio_reg,
  input  logic [15:0]       mdio_wdata,
  output logic [15:0]       mdio_rdata,
  output logic              mdio_rvalid,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_we,
  output logic [WIDX_W-1:0] bus_widx,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bridge_st_e        st_q, st_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [WIDX_W-1:0] req_addr_q, req_addr_d;
  logic [31:0]       req_data_q, req_data_d;
  logic              req_hi_q, req_hi_d;
  logic [15:0]       rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d;

  acc_kind_e         kind;
  logic [WIDX_W-1:0] widx;
  logic              hi_half;
  logic              idle, wr_go, rd_go;
  logic              stage_take, stage_done;
  logic [31:0]       stage_word;
  logic              keep_fill, keep_drop, keep_hit;
  logic [15:0]       keep_data;

  mdiob_decode #(
    .PAGE_W (PAGE_W),
    .WIDX_W (WIDX_W),
    .ID_WIDX(ID_WIDX)
  ) u_decode (
    .page   (page_q),
    .phy    (mdio_phy),
    .reg_num(mdio_reg),
    .kind   (kind),
    .widx   (widx),
    .hi_half(hi_half)
  );

  mdiob_wstage #(.WIDX_W(WIDX_W)) u_wstage (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .take   (stage_take),
    .widx   (widx),
    .hi_half(hi_half),
    .wdata  (mdio_wdata),
    .done   (stage_done),
    .word   (stage_word)
  );

  mdiob_rkeep #(.WIDX_W(WIDX_W)) u_rkeep (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fill     (keep_fill),
    .drop     (keep_drop),
    .fill_addr(req_addr_q),
    .fill_data(bus_rdata[31:16]),
    .look_addr(widx),
    .hit      (keep_hit),
    .data     (keep_data)
  );

  always_comb begin
    idle       = (st_q == ST_IDLE);
    wr_go      = idle && mdio_wr;
    rd_go      = idle && mdio_rd && !mdio_wr;
    stage_take = wr_go && (kind == K_DATA);

    st_d       = st_q;
    page_d     = page_q;
    req_addr_d = req_addr_q;
    req_data_d = req_data_q;
    req_hi_d   = req_hi_q;
    rdata_d    = rdata_q;
    rvalid_d   = 1'b0;
    keep_fill  = 1'b0;
    keep_drop  = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (wr_go) begin
          if (kind == K_PAGE) begin
            page_d = mdio_wdata[PAGE_W-1:0];
          end else if (stage_done) begin
            req_addr_d = widx;
            req_data_d = stage_word;
            keep_drop  = 1'b1;
            st_d       = ST_WR;
          end
        end else if (rd_go) begin
          unique case (kind)
            K_PAGE: begin
              rdata_d  = 16'(page_q);
              rvalid_d = 1'b1;
            end
            K_ID: begin
              rdata_d  = hi_half ? ID_VALUE[31:16] : ID_VALUE[15:0];
              rvalid_d = 1'b1;
            end
            K_DATA: begin
              if (hi_half && keep_hit) begin
                rdata_d   = keep_data;
                rvalid_d  = 1'b1;
                keep_drop = 1'b1;
              end else begin
                req_addr_d = widx;
                req_hi_d   = hi_half;
                st_d       = ST_RD;
              end
            end
            default: begin
              rdata_d  = 16'hFFFF;
              rvalid_d = 1'b1;
            end
          endcase
        end
      end
      ST_RD: begin
        if (bus_ack) begin
          rdata_d   = req_hi_q ? bus_rdata[31:16] : bus_rdata[15:0];
          rvalid_d  = 1'b1;
          keep_fill = !req_hi_q;
          st_d      = ST_IDLE;
        end
      end
      ST_WR: begin
        if (bus_ack) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q       <= ST_IDLE;
      page_q     <= '0;
      req_addr_q <= '0;
      req_data_q <= '0;
      req_hi_q   <= 1'b0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
    end else begin
      st_q       <= st_d;
      page_q     <= page_d;
      req_addr_q <= req_addr_d;
      req_data_q <= req_data_d;
      req_hi_q   <= req_hi_d;
      rdata_q    <= rdata_d;
      rvalid_q   <= rvalid_d;
    end
  end

  assign mdio_rdata  = rdata_q;
  assign mdio_rvalid = rvalid_q;
  assign busy        = !idle;
  assign bus_req     = (st_q == ST_RD) || (st_q == ST_WR);
  assign bus_we      = (st_q == ST_WR);
  assign bus_widx    = req_addr_q;
  assign bus_wdata   = req_data_q;
endmodule

// File: rtl/mdiob_chk.sv
module mdiob_chk #(
  parameter int unsigned PAGE_W  = 16,
  parameter int unsigned ID_WIDX = 'h43,
  parameter int unsigned WIDX_W  = PAGE_W + 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mdio_wr,
  input logic              mdio_rd,
  input logic [4:0]        mdio_phy,
  input logic [4:0]        mdio_reg,
  input logic              mdio_rvalid,
  input logic              busy,
  input logic              bus_req,
  input logic              bus_we,
  input logic [WIDX_W-1:0] bus_widx,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic [PAGE_W-1:0] page
);
  localparam logic [4:0]        ID_PHY  = 5'h10 | 5'((ID_WIDX >> 4) & 7);
  localparam logic [3:0]        ID_REGW = 4'(ID_WIDX & 15);
  localparam logic [PAGE_W-1:0] ID_PAGE = PAGE_W'(ID_WIDX >> 7);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_widx) && $stable(bus_we) && $stable(bus_wdata))); // R12

  AST_BUSY_ENDS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bus_ack)); // R11

  AST_RD_ACK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_we) |=> mdio_rvalid); // R6

  AST_WR_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_we) |=> !mdio_rvalid); // R4

  AST_ID_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mdio_rd && !mdio_wr && mdio_phy == ID_PHY && mdio_reg[4:1] == ID_REGW && page == ID_PAGE)
    |=> (!bus_req && mdio_rvalid)); // R9

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (mdio_rd || mdio_wr) && mdio_phy[4:3] != 2'b10 && mdio_phy != 5'h1F)
    |=> (!bus_req && $stable(page))); // R10
endmodule

bind mdio_page_bridge mdiob_chk #(
  .PAGE_W (PAGE_W),
  .ID_WIDX(ID_WIDX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mdio_wr    (mdio_wr),
  .mdio_rd    (mdio_rd),
  .mdio_phy   (mdio_phy),
  .mdio_reg   (mdio_reg),
  .mdio_rvalid(mdio_rvalid),
  .busy       (busy),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_widx   (bus_widx),
  .bus_wdata  (bus_wdata),
  .bus_ack    (bus_ack),
  .page       (page_q)
);

// File: tb/test_mdio_page_bridge.sv
module test_mdio_page_bridge;
  localparam int unsigned PAGE_W = 16;
  localparam int unsigned WIDX_W = PAGE_W + 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mdio_wr, mdio_rd;
  logic [4:0]        mdio_phy, mdio_reg;
  logic [15:0]       mdio_wdata;
  logic [15:0]       mdio_rdata;
  logic              mdio_rvalid, busy, bus_req, bus_we, bus_ack;
  logic [WIDX_W-1:0] bus_widx;
  logic [31:0]       bus_wdata, bus_rdata;

  mdio_page_bridge i_mdio_page_bridge (
    .clk(clk), .rst_n(rst_n),
    .mdio_wr(mdio_wr), .mdio_rd(mdio_rd), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_wdata(mdio_wdata), .mdio_rdata(mdio_rdata), .mdio_rvalid(mdio_rvalid),
    .busy(busy), .bus_req(bus_req), .bus_we(bus_we), .bus_widx(bus_widx),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  always #5ns clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // bench memory model of the internal register file
  logic [31:0] mem [int unsigned];
  int n_bus_rd = 0, n_bus_wr = 0;
  int mem_delay = 0, dly_cnt = 0;
  int unsigned last_wr_idx = 0;

  function automatic logic [31:0] defv(int unsigned w);
    return {w[15:0] ^ 16'h5A3C, ~w[15:0]};
  endfunction

  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (dly_cnt >= mem_delay) begin
        dly_cnt = 0;
        bus_ack = 1'b1;
        if (bus_we) begin
          mem[int'(bus_widx)] = bus_wdata;
          last_wr_idx = int'(bus_widx);
          n_bus_wr++;
        end else begin
          bus_rdata = mem.exists(int'(bus_widx)) ? mem[int'(bus_widx)] : defv(int'(bus_widx));
          n_bus_rd++;
        end
      end else begin
        dly_cnt++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    mdio_phy = p; mdio_reg = r; mdio_wdata = d; mdio_wr = 1'b1;
    @(negedge clk);
    mdio_wr = 1'b0;
    for (int n = 0; n < 100 && busy; n++) @(negedge clk);
  endtask

  task automatic do_rd(input logic [4:0] p, input logic [4:0] r, output logic [15:0] d, output bit got);
    @(negedge clk);
    mdio_phy = p; mdio_reg = r; mdio_rd = 1'b1;
    @(negedge clk);
    mdio_rd = 1'b0;
    for (int n = 0; n < 100 && !mdio_rvalid; n++) @(negedge clk);
    got = mdio_rvalid;
    d = mdio_rdata;
  endtask

  // reference model state
  logic [15:0] m_page;
  int unsigned m_st_addr, m_kp_addr;
  bit m_st_lo_v, m_st_hi_v, m_kp_v;
  logic [15:0] m_st_lo, m_st_hi, m_kp;
  logic [31:0] m_mem [int unsigned];
  int m_wr = 0;

  function automatic int unsigned widx_of(logic [4:0] p, logic [4:0] r);
    return {9'd0, m_page, p[2:0], r[4:1]};
  endfunction

  function automatic logic [31:0] m_word(int unsigned w);
    return m_mem.exists(w) ? m_mem[w] : defv(w);
  endfunction

  function automatic void m_write(logic [4:0] p, logic [4:0] r, logic [15:0] d);
    int unsigned w;
    if (p == 5'h1F && r == 5'h10) begin m_page = d; return; end
    if (p[4:3] != 2'b10) return;
    w = widx_of(p, r);
    if (w == 'h43) return;
    if (m_st_addr == w && (r[0] ? m_st_lo_v : m_st_hi_v)) begin
      m_mem[w] = r[0] ? {d, m_st_lo} : {m_st_hi, d};
      m_st_lo_v = 0; m_st_hi_v = 0; m_kp_v = 0; m_wr++;
    end else begin
      m_st_addr = w; m_st_lo_v = !r[0]; m_st_hi_v = r[0];
      if (r[0]) m_st_hi = d; else m_st_lo = d;
    end
  endfunction

  function automatic logic [15:0] m_read(logic [4:0] p, logic [4:0] r);
    int unsigned w;
    logic [31:0] v;
    if (p == 5'h1F && r == 5'h10) return m_page;
    if (p[4:3] != 2'b10) return 16'hFFFF;
    w = widx_of(p, r);
    if (w == 'h43) return r[0] ? 16'h1800 : 16'h7FFF;
    if (r[0] && m_kp_v && m_kp_addr == w) begin m_kp_v = 0; return m_kp; end
    v = m_word(w);
    if (!r[0]) begin m_kp_v = 1; m_kp_addr = w; m_kp = v[31:16]; return v[15:0]; end
    return v[31:16];
  endfunction

  initial begin
    #(2_000_000ns);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    bit got;
    int b0, w0;
    void'($urandom(32'h1BADCAFE));
    mdio_wr = 0; mdio_rd = 0; mdio_phy = 0; mdio_reg = 0; mdio_wdata = 0;
    bus_ack = 0; bus_rdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 bus_req", {31'd0, bus_req}, 0);
    check("R1 rvalid", {31'd0, mdio_rvalid}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    do_rd(5'h1F, 5'h10, d, got);
    check("R1 page after reset", {15'd0, got, d}, {15'd0, 1'b1, 16'h0000});

    // R2 page write / readback
    do_wr(5'h1F, 5'h10, 16'h00A7);
    do_rd(5'h1F, 5'h10, d, got);
    check("R2 page readback", {16'd0, d}, 32'h00A7);
    do_wr(5'h1F, 5'h10, 16'h0000);

    // R3/R4 low then high to command word 0x26
    w0 = n_bus_wr;
    do_wr(5'h12, 5'h0C, 16'h1234);
    check("R4 no commit after one half", n_bus_wr, w0);
    do_wr(5'h12, 5'h0D, 16'hC0DE);
    check("R4 commit after second half", n_bus_wr, w0 + 1);
    check("R3 word index", last_wr_idx, 32'h26);
    check("R4 word data low-first", mem[32'h26], 32'hC0DE_1234);

    // R4 high then low, on page 2
    do_wr(5'h1F, 5'h10, 16'h0002);
    do_wr(5'h17, 5'h1F, 16'hBEEF);
    do_wr(5'h17, 5'h1E, 16'h0F0F);
    check("R3 paged index", last_wr_idx, (2 << 7) | 'h7F);
    check("R4 word data high-first", mem[(2 << 7) | 'h7F], 32'hBEEF_0F0F);
    do_wr(5'h1F, 5'h10, 16'h0000);

    // R5 restaging
    w0 = n_bus_wr;
    do_wr(5'h10, 5'h02, 16'h1111);
    do_wr(5'h10, 5'h04, 16'h2222);
    do_wr(5'h10, 5'h05, 16'h3333);
    check("R5 new word commits", mem[2], 32'h3333_2222);
    do_wr(5'h10, 5'h03, 16'h4444);
    check("R5 discarded half not paired", n_bus_wr, w0 + 1);
    do_wr(5'h10, 5'h08, 16'h5555);
    do_wr(5'h10, 5'h08, 16'h6666);
    do_wr(5'h10, 5'h09, 16'h7777);
    check("R5 same half replaced", mem[4], 32'h7777_6666);

    // R6/R7 low then high read
    mem_delay = 2;
    b0 = n_bus_rd;
    do_rd(5'h11, 5'h06, d, got);
    check("R6 low read data", {16'd0, d}, {16'd0, defv('h13) & 32'hFFFF});
    do_rd(5'h11, 5'h07, d, got);
    check("R7 kept high data", {16'd0, d}, {16'd0, defv('h13) >> 16});
    check("R7 one bus read only", n_bus_rd, b0 + 1);
    do_rd(5'h11, 5'h07, d, got);
    check("R7 second high read refetches", n_bus_rd, b0 + 2);

    // R8 write in between drops kept half
    do_rd(5'h11, 5'h0A, d, got);
    do_wr(5'h11, 5'h0A, 16'hAAAA);
    do_wr(5'h11, 5'h0B, 16'hBBBB);
    do_rd(5'h11, 5'h0B, d, got);
    check("R8 high read after write", {16'd0, d}, 32'hBBBB);

    // R9 integrity word
    b0 = n_bus_rd; w0 = n_bus_wr;
    do_rd(5'h14, 5'h06, d, got);
    check("R9 id low", {16'd0, d}, 32'h7FFF);
    do_rd(5'h14, 5'h07, d, got);
    check("R9 id high", {16'd0, d}, 32'h1800);
    do_wr(5'h14, 5'h06, 16'h0000);
    do_wr(5'h14, 5'h07, 16'h0000);
    do_rd(5'h14, 5'h06, d, got);
    check("R9 id after write", {16'd0, d}, 32'h7FFF);
    check("R9 no bus traffic", n_bus_rd + n_bus_wr, b0 + w0);

    // R10 unmapped
    do_rd(5'h05, 5'h00, d, got);
    check("R10 unmapped read", {16'd0, d}, 32'hFFFF);
    do_rd(5'h1F, 5'h11, d, got);
    check("R10 page device other reg", {16'd0, d}, 32'hFFFF);
    do_wr(5'h05, 5'h10, 16'h0033);
    do_wr(5'h1F, 5'h11, 16'h0044);
    do_rd(5'h1F, 5'h10, d, got);
    check("R10 page untouched", {16'd0, d}, 32'h0000);

    // R11 both strobes together
    @(negedge clk);
    mdio_phy = 5'h1F; mdio_reg = 5'h10; mdio_wdata = 16'h0009; mdio_wr = 1; mdio_rd = 1;
    @(negedge clk);
    mdio_wr = 0; mdio_rd = 0;
    check("R11 read dropped", {31'd0, mdio_rvalid}, 0);
    do_rd(5'h1F, 5'h10, d, got);
    check("R11 write taken", {16'd0, d}, 32'h0009);
    do_wr(5'h1F, 5'h10, 16'h0000);

    // R11 strobe while busy
    mem_delay = 10;
    @(negedge clk);
    mdio_phy = 5'h10; mdio_reg = 5'h00; mdio_rd = 1;
    @(negedge clk);
    mdio_rd = 0;
    @(negedge clk);
    check("R12 request held", {31'd0, bus_req}, 1);
    mdio_phy = 5'h1F; mdio_reg = 5'h10; mdio_wdata = 16'h0055; mdio_wr = 1;
    @(negedge clk);
    mdio_wr = 0;
    for (int n = 0; n < 100 && !mdio_rvalid; n++) @(negedge clk);
    do_rd(5'h1F, 5'h10, d, got);
    check("R11 strobe during busy ignored", {16'd0, d}, 32'h0000);

    // random phase against the reference model
    m_page = 0; m_st_addr = 'hFFFFFFFF; m_st_lo_v = 0; m_st_hi_v = 0; m_kp_v = 0;
    m_st_lo = 0; m_st_hi = 0; m_kp = 0; m_kp_addr = 0;
    foreach (mem[k]) m_mem[k] = mem[k];
    do_rd(5'h10, 5'h00, d, got); // align keep state: low read of word 0
    void'(m_read(5'h10, 5'h00));
    m_wr = n_bus_wr;
    for (int i = 0; i < 500; i++) begin
      int sel;
      logic [4:0] p, r;
      logic [15:0] wd, e;
      sel = int'($urandom_range(0, 19));
      mem_delay = int'($urandom_range(0, 3));
      if (sel == 0)      begin p = 5'h1F; r = 5'h10; end
      else if (sel == 1) begin p = 5'h03; r = 5'($urandom_range(0, 31)); end
      else if (sel == 2) begin p = 5'h14; r = 5'($urandom_range(6, 7)); end
      else begin p = 5'h10 | 5'($urandom_range(0, 1)); r = 5'($urandom_range(0, 5)); end
      wd = (p == 5'h1F) ? 16'($urandom_range(0, 1)) : 16'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        do_wr(p, r, wd);
        m_write(p, r, wd);
      end else begin
        e = m_read(p, r);
        do_rd(p, r, d, got);
        check($sformatf("R3 R6 R7 random read %0d", i), {15'd0, got, d}, {15'd0, 1'b1, e});
      end
    end
    check("R4 random commit count", n_bus_wr, m_wr);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule